// File: doc/BRIEF.md
# One-Shot Event Timer with Free-Running Timebase

This block is a bus-mapped timer. It holds a 32-bit timebase that counts up on every clock and never stops. It also holds one down-counting event counter that software arms for a single expiry. Software writes a start value into the divisor register. It then writes the control register with the load operation, which copies the divisor into the counter. A second control write selects the run operation, and the counter starts counting down.

When a running counter steps from one to zero, it latches an interrupt cause and parks at zero. A mask bit gates the cause onto the masked-status register and onto the interrupt output. Writing one to the acknowledge register clears the cause. The current count can be read at any time, so the elapsed ticks equal the divisor minus the count. The counter advances either on every clock or once every `SLOW_DIV` clocks, as set by a rate bit in control.

Top module: `evt_timer`

## Requirements
- R1: The timebase (address 0) resets to 0 and increments by one on every clock. A bus write to address 0 has no effect on it.
- R2: Word addresses: 0 timebase (read-only), 1 divisor, 2 control, 3 current count (read-only), 4 mask (bit 0), 5 masked status (bit 0), 6 acknowledge (write-only, reads 0). Control bits [1:0] hold the operation: 0 hold, 1 load, 2 run, 3 behaves as hold. Control bit 2 selects the rate: 0 means every clock, 1 means once every `SLOW_DIV` clocks.
- R3: While the operation is load, each clock copies the divisor into the count.
- R4: While the operation is run, the count drops by one per selected tick. With full rate, the count read between the clock edge that latches the run write and the following edge equals the divisor, and it is one lower at each later edge.
- R5: When a running count steps from 1 to 0, the cause bit sets and the count stays at 0 with no reload.
- R6: While the operation is hold, the count keeps its value.
- R7: Masked status bit 0 equals cause AND mask. The `irq` output is high exactly when masked status is non-zero.
- R8: Writing 1 to acknowledge bit 0 clears the cause, and writing 0 leaves it set. An expiry in the same clock as an acknowledge leaves the cause set.
- R9: With the rate bit set, any window of `k*SLOW_DIV` consecutive clocks in run lowers the count by exactly `k`, as long as it stays above zero.
- R10: Reset clears divisor, control, count, mask and cause, and it drives `irq` low.
- R11: Running with a count of 0 never sets the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| irq | output | 1 | Masked interrupt request |

## Verification
The arm-run-expire sequence is driven with divisors of 1, 2, 7 and 20, using both mask settings. Each run shows whether the count starts from the divisor in the right cycle and lands at zero exactly when expected. The mask-off runs confirm that the cause is still recorded, because it only appears on `irq` once the mask is raised. Further patterns cover:
- freezing under hold;
- the divided rate, measured over a fixed window;
- a zero divisor;
- an acknowledge that lands on the expiry clock.

These show whether set wins over clear and whether a stopped counter can raise a false event.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int AW       = 3,
  parameter int SLOW_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [AW-1:0] A_TB   = AW'(0);
  localparam logic [AW-1:0] A_DIV  = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [AW-1:0] A_CNT  = AW'(3);
  localparam logic [AW-1:0] A_MASK = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam logic [AW-1:0] A_ACK  = AW'(6);
  localparam logic [1:0] OP_LOAD = 2'd1;
  localparam logic [1:0] OP_RUN  = 2'd2;

  logic [31:0]   tb_q, div_q, count_q;
  logic [1:0]    op_q;
  logic          rate_q, mask_q, cause_q;
  logic [PW-1:0] pre_q;
  logic          tick, expire, ack_clr;

  wire wr_go = bus_sel & bus_wr;

  assign tick    = !rate_q || (pre_q == PW'(SLOW_DIV - 1));
  assign expire  = (op_q == OP_RUN) && tick && (count_q == 32'd1);
  assign ack_clr = wr_go && (bus_addr == A_ACK) && bus_wdata[0];
  assign irq     = cause_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_q + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pre_q == PW'(SLOW_DIV - 1)) pre_q <= '0;
    else                                      pre_q <= pre_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      op_q   <= '0;
      rate_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_go) begin
      if (bus_addr == A_DIV)  div_q <= bus_wdata;
      if (bus_addr == A_CTRL) begin
        op_q   <= bus_wdata[1:0];
        rate_q <= bus_wdata[2];
      end
      if (bus_addr == A_MASK) mask_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else begin
      case (op_q)
        OP_LOAD: count_q <= div_q;
        OP_RUN:  if (tick && count_q != 32'd0) count_q <= count_q - 32'd1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cause_q <= 1'b0;
    else if (expire)  cause_q <= 1'b1;
    else if (ack_clr) cause_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_TB:    bus_rdata = tb_q;
      A_DIV:   bus_rdata = div_q;
      A_CTRL:  bus_rdata = {29'd0, rate_q, op_q};
      A_CNT:   bus_rdata = count_q;
      A_MASK:  bus_rdata = {31'd0, mask_q};
      A_STAT:  bus_rdata = {31'd0, irq};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] tb_q,
  input logic [31:0] count_q,
  input logic [31:0] div_q,
  input logic [1:0]  op_q,
  input logic        tick,
  input logic        cause_q,
  input logic        ack_clr
);
  AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> tb_q == $past(tb_q) + 32'd1); // R1
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    op_q == 2'd1 |=> count_q == $past(div_q)); // R3
  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 2'd2 && count_q != 32'd0) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) - 32'd1)); // R4
  AST_ZERO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 2'd2 && count_q == 32'd0) |=> count_q == 32'd0); // R5
  AST_EXPIRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 2'd2 && tick && count_q == 32'd1) |=> cause_q); // R5
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 2'd0 || op_q == 2'd3) |=> $stable(count_q)); // R6
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !(op_q == 2'd2 && tick && count_q == 32'd1)) |=> !cause_q); // R8
endmodule

bind evt_timer evt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tb_q(tb_q), .count_q(count_q), .div_q(div_q),
  .op_q(op_q), .tick(tick), .cause_q(cause_q), .ack_clr(ack_clr)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int AW = 3;
  localparam int SD = 4;
  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  evt_timer #(.AW(AW), .SLOW_DIV(SD)) u_evt_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #2 clk = ~clk;

  // {divisor, mask}
  localparam logic [32:0] VEC [4] = '{{32'd1, 1'b1}, {32'd2, 1'b1}, {32'd7, 1'b0}, {32'd20, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_sel = 1'b1; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); #1 d = bus_rdata;
  endtask

  task automatic peek(input int a, output logic [31:0] d);
    bus_addr = AW'(a); #1 d = bus_rdata;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    peek(0, v); chk("R1 tb in reset", v, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 1; a < 7; a++) begin
      rd(a, v); chk("R10 reset value", v, 0);
    end
    chk("R10 irq after reset", {31'd0, irq}, 0);

    rd(0, v); repeat (9) @(negedge clk); peek(0, v2);
    chk("R1 timebase step", v2 - v, 9);
    rd(0, v); wr(0, 32'd0); rd(0, v2);
    chk("R1 write ignored", v2 - v, 2);
    rd(2, v); wr(2, 32'h7); rd(2, v2);
    chk("R2 control readback", v2, 32'h7);
    wr(2, 32'h0);

    foreach (VEC[i]) begin
      logic [31:0] d; logic m;
      d = VEC[i][32:1]; m = VEC[i][0];
      wr(4, {31'd0, m});
      wr(6, 32'd1);
      wr(1, d); wr(2, 32'd1); wr(2, 32'd2);
      @(negedge clk); peek(3, v); chk("R3 count loaded", v, d);
      if (d > 1) begin
        repeat (d - 1) @(negedge clk);
        peek(3, v); chk("R4 count before end", v, 1);
      end
      chk("R4 irq before end", {31'd0, irq}, 0);
      @(negedge clk); peek(3, v); chk("R5 count at zero", v, 0);
      chk("R7 irq follows mask", {31'd0, irq}, {31'd0, m});
      peek(5, v); chk("R7 masked status", v, {31'd0, m});
      repeat (3) @(negedge clk); peek(3, v); chk("R5 no reload", v, 0);
      if (!m) begin
        wr(4, 32'd1); @(negedge clk);
        chk("R7 cause kept under mask", {31'd0, irq}, 1);
      end
      wr(6, 32'd0); @(negedge clk); chk("R8 ack zero no effect", {31'd0, irq}, 1);
      wr(6, 32'd1); rd(5, v); chk("R8 ack clears", v, 0);
    end

    wr(4, 32'd1);
    wr(1, 32'd50); wr(2, 32'd1); wr(2, 32'd2);
    repeat (5) @(negedge clk);
    wr(2, 32'd0); rd(3, v); repeat (10) @(negedge clk); peek(3, v2);
    chk("R6 hold freezes", v2, v);
    wr(2, 32'd3); repeat (4) @(negedge clk); peek(3, v2);
    chk("R6 op 3 holds", v2, v);

    wr(1, 32'd100); wr(2, 32'd1); wr(2, 32'd6);
    rd(3, v); repeat (10 * SD) @(negedge clk); peek(3, v2);
    chk("R9 slow rate", v - v2, 10);

    wr(1, 32'd0); wr(2, 32'd1); wr(2, 32'd2);
    repeat (6) @(negedge clk); peek(5, v);
    chk("R11 zero run no cause", v, 0);

    wr(1, 32'd1); wr(2, 32'd1); wr(2, 32'd2); wr(6, 32'd1);
    @(negedge clk); chk("R8 set beats ack", {31'd0, irq}, 1);

    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R10 irq cleared", {31'd0, irq}, 0);
    rd(4, v); chk("R10 mask cleared", v, 0);
    rd(1, v); chk("R10 divisor cleared", v, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule